// File: doc/BRIEF.md
# CRT Raster Timing Controller

This block generates the raster timing of a character-based display. A host programs an indexed bank of 25 byte-wide timing registers through two byte ports: one port selects a register, the other reads or writes the selected register. Several timing limits are wider than one byte. Their upper bits sit in shared overflow registers, and the block assembles each field from its pieces before comparing it with the raster counters.

The pixel clock divides into character clocks of `CHAR_PIX` pixels. A character counter steps once per character clock and a line counter steps once per wrapped line. Registered comparators set and clear horizontal sync, horizontal blank, vertical sync and vertical blank. Display enable and a line-compare match follow the counters directly. A lock bit in the vertical-retrace-end register guards the eight low timing registers against accidental rewrites. All outputs are active high.

Top module: `crtc_timing`

## Requirements
- R1: `reg_sel`=0 addresses the index port: a write stores `reg_wdata[4:0]` as the index, and a read returns the index zero-extended to 8 bits. `reg_sel`=1 addresses the data port, which reads or writes register[index]. For an index of 25 or above, data writes are dropped and data reads return 0x00.
- R2: While `rst_n` is low, every register and the index are 0x00, both counters are 0, and `char_ce`, `hsync`, `hblank`, `vsync`, `vblank` are low.
- R3: While bit 7 of register 0x11 is 1, data writes to registers 0x00–0x07 are ignored and writes to the other registers still land. Writing 0 to that bit makes registers 0x00–0x07 writable again.
- R4: `char_ce` is high for one clock in every `CHAR_PIX` (8) clocks. It is first high on the 7th rising edge after reset is released.
- R5: The character counter steps on `char_ce` and returns to 0 when it is at or above register 0x00 + 4. A line therefore lasts (register 0x00 + 5) characters.
- R6: The line counter steps when the character counter wraps, and it returns to 0 when it is at or above VT + 1, so a frame lasts VT + 2 lines. VT = {reg 0x07 bit 5, reg 0x07 bit 0, reg 0x06}.
- R7: `disp_en` is high exactly when the character counter ≤ register 0x01 and the line counter ≤ VDE, where VDE = {reg 0x07 bit 6, reg 0x07 bit 1, reg 0x12}.
- R8: `hblank` sets on entering the character equal to register 0x02 + 1. It clears on entering a character whose low 6 bits equal {reg 0x05 bit 7, reg 0x03 bits 4:0}. Setting wins if both match.
- R9: `hsync` sets on entering the character equal to register 0x04, and clears on entering a character whose low 5 bits equal register 0x05 bits 4:0. Setting wins if both match.
- R10: `vsync` sets on entering the line equal to VRS = {reg 0x07 bit 7, reg 0x07 bit 2, reg 0x10}, and clears on entering a line whose low 4 bits equal register 0x11 bits 3:0. Setting wins if both match.
- R11: `vblank` sets on entering the line equal to VBS = {reg 0x09 bit 5, reg 0x07 bit 3, reg 0x15}, and clears on entering a line whose low 8 bits equal register 0x16. Setting wins if both match.
- R12: `lcmp_hit` is high exactly while the line counter equals LC = {reg 0x09 bit 6, reg 0x07 bit 4, reg 0x18}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| reg_we | input | 1 | Write strobe for the selected port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data from the selected port |
| char_ce | output | 1 | Character clock enable |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blank |
| vsync | output | 1 | Vertical sync |
| vblank | output | 1 | Vertical blank |
| disp_en | output | 1 | Active display region |
| lcmp_hit | output | 1 | Line counter equals the line-compare value |

## Verification
An off-by-one in the character counter or in a wrap limit moves every sync and blank edge. The per-cycle comparison against the bench's own raster model flags this within one line. A dropped or misplaced overflow bit changes the frame length or the line on which a vertical edge falls, so it shows within one frame. An error in the write lock or the index decode shows at the next readback of the affected register, a few clocks after the write.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

   localparam int NUM_REGS = 25;
   localparam int IDX_W    = 5;
   localparam int HCNT_W   = 9;
   localparam int VCNT_W   = 10;

   // register slots whose positions are decoded by the field assembly
   localparam int RG_HTOT = 0;
   localparam int RG_HDE  = 1;
   localparam int RG_HBS  = 2;
   localparam int RG_HBE  = 3;
   localparam int RG_HSS  = 4;
   localparam int RG_HSE  = 5;
   localparam int RG_VTOT = 6;
   localparam int RG_OVF  = 7;
   localparam int RG_OVF2 = 9;
   localparam int RG_VRS  = 16;
   localparam int RG_VRE  = 17;
   localparam int RG_VDE  = 18;
   localparam int RG_VBS  = 21;
   localparam int RG_VBE  = 22;
   localparam int RG_LCMP = 24;
   localparam int LOCK_LAST = 7;
   localparam int LOCK_BIT  = 7;

   typedef struct packed {
      logic [7:0] htotal;
      logic [7:0] hde;
      logic [7:0] hbs;
      logic [5:0] hbe;
      logic [7:0] hss;
      logic [4:0] hse;
      logic [9:0] vt;
      logic [9:0] vrs;
      logic [3:0] vre;
      logic [9:0] vde;
      logic [9:0] vbs;
      logic [7:0] vbe;
      logic [9:0] lcmp;
   } crtc_fields_t;

endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
   import crtc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             we,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic [IDX_W-1:0] idx_q,
   output logic             lock,
   output crtc_fields_t     fields
);

   logic [7:0] regs [NUM_REGS];
   logic       idx_ok;

   assign idx_ok = idx_q < IDX_W'(NUM_REGS);
   assign lock   = regs[RG_VRE][LOCK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (we && !sel)
         idx_q <= wdata[IDX_W-1:0];
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      localparam bit GUARDED = (g <= LOCK_LAST);
      logic [7:0] q;
      logic       hit;
      assign hit = we && sel && (idx_q == IDX_W'(g)) && !(GUARDED && lock);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (hit)
            q <= wdata;
      end
      assign regs[g] = q;
   end

   always_comb begin
      if (!sel)
         rdata = 8'(idx_q);
      else if (idx_ok)
         rdata = regs[idx_q];
      else
         rdata = 8'h00;
   end

   // gather split timing fields from their overflow pieces
   always_comb begin
      fields.htotal = regs[RG_HTOT];
      fields.hde    = regs[RG_HDE];
      fields.hbs    = regs[RG_HBS];
      fields.hbe    = {regs[RG_HSE][7], regs[RG_HBE][4:0]};
      fields.hss    = regs[RG_HSS];
      fields.hse    = regs[RG_HSE][4:0];
      fields.vt     = {regs[RG_OVF][5], regs[RG_OVF][0], regs[RG_VTOT]};
      fields.vrs    = {regs[RG_OVF][7], regs[RG_OVF][2], regs[RG_VRS]};
      fields.vre    = regs[RG_VRE][3:0];
      fields.vde    = {regs[RG_OVF][6], regs[RG_OVF][1], regs[RG_VDE]};
      fields.vbs    = {regs[RG_OVF2][5], regs[RG_OVF][3], regs[RG_VBS]};
      fields.vbe    = regs[RG_VBE];
      fields.lcmp   = {regs[RG_OVF2][6], regs[RG_OVF][4], regs[RG_LCMP]};
   end

endmodule

// File: rtl/crtc_chargen.sv
module crtc_chargen #(
   parameter int CHAR_PIX = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic char_ce
);

   if (CHAR_PIX == 1) begin : g_every
      assign char_ce = 1'b1;
   end else begin : g_div
      localparam int PIX_W = $clog2(CHAR_PIX);
      logic [PIX_W-1:0] cnt;
      logic             last;
      assign last = (cnt == PIX_W'(CHAR_PIX - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (last)
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
      assign char_ce = last;
   end

endmodule

// File: rtl/crtc_scan.sv
module crtc_scan
   import crtc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_ce,
   input  logic [7:0]        htotal,
   input  logic [7:0]        hbs,
   input  logic [5:0]        hbe,
   input  logic [7:0]        hss,
   input  logic [4:0]        hse,
   input  logic [9:0]        vt,
   input  logic [9:0]        vrs,
   input  logic [3:0]        vre,
   input  logic [9:0]        vbs,
   input  logic [7:0]        vbe,
   output logic [HCNT_W-1:0] hcnt,
   output logic [VCNT_W-1:0] vcnt,
   output logic              hsync,
   output logic              hblank,
   output logic              vsync,
   output logic              vblank
);

   logic [HCNT_W-1:0] hlast, hnext, hb_at;
   logic [VCNT_W:0]   vlast;
   logic [VCNT_W-1:0] vnext;
   logic              hwrap, vwrap;

   assign hlast = HCNT_W'(htotal) + HCNT_W'(4);
   assign hb_at = HCNT_W'(hbs) + HCNT_W'(1);
   assign hwrap = (hcnt >= hlast);
   assign hnext = hwrap ? '0 : hcnt + 1'b1;

   assign vlast = (VCNT_W+1)'(vt) + (VCNT_W+1)'(1);
   assign vwrap = ({1'b0, vcnt} >= vlast);
   assign vnext = vwrap ? '0 : vcnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt   <= '0;
         hsync  <= 1'b0;
         hblank <= 1'b0;
      end else if (char_ce) begin
         hcnt <= hnext;
         if (hnext == HCNT_W'(hss))
            hsync <= 1'b1;
         else if (hnext[4:0] == hse)
            hsync <= 1'b0;
         if (hnext == hb_at)
            hblank <= 1'b1;
         else if (hnext[5:0] == hbe)
            hblank <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vcnt   <= '0;
         vsync  <= 1'b0;
         vblank <= 1'b0;
      end else if (char_ce && hwrap) begin
         vcnt <= vnext;
         if (vnext == vrs)
            vsync <= 1'b1;
         else if (vnext[3:0] == vre)
            vsync <= 1'b0;
         if (vnext == vbs)
            vblank <= 1'b1;
         else if (vnext[7:0] == vbe)
            vblank <= 1'b0;
      end
   end

endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
   import crtc_pkg::*;
#(
   parameter int CHAR_PIX = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_sel,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       char_ce,
   output logic       hsync,
   output logic       hblank,
   output logic       vsync,
   output logic       vblank,
   output logic       disp_en,
   output logic       lcmp_hit
);

   if (CHAR_PIX < 1 || CHAR_PIX > 64) begin : g_bad_char_pix
      $error("crtc_timing: CHAR_PIX must lie in 1..64");
   end

   crtc_fields_t      fields;
   logic [IDX_W-1:0]  cur_idx;
   logic              wr_lock;
   logic [HCNT_W-1:0] hcnt;
   logic [VCNT_W-1:0] vcnt;

   crtc_regfile u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (reg_sel),
      .we     (reg_we),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .idx_q  (cur_idx),
      .lock   (wr_lock),
      .fields (fields)
   );

   crtc_chargen #(.CHAR_PIX(CHAR_PIX)) u_chargen (
      .clk     (clk),
      .rst_n   (rst_n),
      .char_ce (char_ce)
   );

   crtc_scan u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .char_ce (char_ce),
      .htotal  (fields.htotal),
      .hbs     (fields.hbs),
      .hbe     (fields.hbe),
      .hss     (fields.hss),
      .hse     (fields.hse),
      .vt      (fields.vt),
      .vrs     (fields.vrs),
      .vre     (fields.vre),
      .vbs     (fields.vbs),
      .vbe     (fields.vbe),
      .hcnt    (hcnt),
      .vcnt    (vcnt),
      .hsync   (hsync),
      .hblank  (hblank),
      .vsync   (vsync),
      .vblank  (vblank)
   );

   assign disp_en  = (hcnt <= HCNT_W'(fields.hde)) && (vcnt <= fields.vde);
   assign lcmp_hit = (vcnt == fields.lcmp);

endmodule

// File: rtl/crtc_timing_checker.sv
module crtc_timing_checker
   import crtc_pkg::*;
#(
   parameter int CHAR_PIX = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_sel,
   input logic              reg_we,
   input logic              char_ce,
   input logic              hsync,
   input logic              vsync,
   input logic [HCNT_W-1:0] hcnt,
   input logic [VCNT_W-1:0] vcnt,
   input logic [IDX_W-1:0]  cur_idx,
   input logic              wr_lock,
   input logic [7:0]        htotal
);

   assert_ce_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (CHAR_PIX > 1 && char_ce) |=> !char_ce);

   assert_hcnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !char_ce |=> $stable(hcnt));

   assert_vcnt_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vcnt) |-> (hcnt == '0));

   assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel && cur_idx == '0 && wr_lock) |=> $stable(htotal));

   assert_hsync_on_char_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !char_ce |=> $stable(hsync));

   assert_vsync_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vsync) |-> (hcnt == '0));

endmodule

bind crtc_timing crtc_timing_checker #(.CHAR_PIX(CHAR_PIX)) u_check (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_sel (reg_sel),
   .reg_we  (reg_we),
   .char_ce (char_ce),
   .hsync   (hsync),
   .vsync   (vsync),
   .hcnt    (hcnt),
   .vcnt    (vcnt),
   .cur_idx (cur_idx),
   .wr_lock (wr_lock),
   .htotal  (fields.htotal)
);

// File: tb/crtc_timing_test.sv
module crtc_timing_test;

   localparam int CP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       char_ce, hsync, hblank, vsync, vblank, disp_en, lcmp_hit;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   crtc_timing #(.CHAR_PIX(CP)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .char_ce   (char_ce),
      .hsync     (hsync),
      .hblank    (hblank),
      .vsync     (vsync),
      .vblank    (vblank),
      .disp_en   (disp_en),
      .lcmp_hit  (lcmp_hit)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // independent raster model built from the requirements
   logic [7:0] m_reg [25];
   int m_idx, m_pix, m_hc, m_vc;
   bit m_hs, m_hb, m_vs, m_vb;
   int t_hl, t_vl, t_nh, t_nv;
   bit t_ce;

   function automatic int f_vt();
      return int'(m_reg[6]) | (int'(m_reg[7][0]) << 8) | (int'(m_reg[7][5]) << 9);
   endfunction
   function automatic int f_vrs();
      return int'(m_reg[16]) | (int'(m_reg[7][2]) << 8) | (int'(m_reg[7][7]) << 9);
   endfunction
   function automatic int f_vde();
      return int'(m_reg[18]) | (int'(m_reg[7][1]) << 8) | (int'(m_reg[7][6]) << 9);
   endfunction
   function automatic int f_vbs();
      return int'(m_reg[21]) | (int'(m_reg[7][3]) << 8) | (int'(m_reg[9][5]) << 9);
   endfunction
   function automatic int f_lc();
      return int'(m_reg[24]) | (int'(m_reg[7][4]) << 8) | (int'(m_reg[9][6]) << 9);
   endfunction
   function automatic int f_hbe();
      return int'(m_reg[3][4:0]) | (int'(m_reg[5][7]) << 5);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 25; i++) m_reg[i] <= 8'h00;
         m_idx <= 0; m_pix <= 0; m_hc <= 0; m_vc <= 0;
         m_hs <= 0; m_hb <= 0; m_vs <= 0; m_vb <= 0;
      end else begin
         t_ce = (m_pix == CP - 1);
         t_hl = int'(m_reg[0]) + 4;
         t_vl = f_vt() + 1;
         m_pix <= t_ce ? 0 : m_pix + 1;
         if (t_ce) begin
            t_nh = (m_hc >= t_hl) ? 0 : m_hc + 1;
            m_hc <= t_nh;
            if (t_nh == int'(m_reg[4])) m_hs <= 1;
            else if ((t_nh & 31) == int'(m_reg[5][4:0])) m_hs <= 0;
            if (t_nh == int'(m_reg[2]) + 1) m_hb <= 1;
            else if ((t_nh & 63) == f_hbe()) m_hb <= 0;
            if (m_hc >= t_hl) begin
               t_nv = (m_vc >= t_vl) ? 0 : m_vc + 1;
               m_vc <= t_nv;
               if (t_nv == f_vrs()) m_vs <= 1;
               else if ((t_nv & 15) == int'(m_reg[17][3:0])) m_vs <= 0;
               if (t_nv == f_vbs()) m_vb <= 1;
               else if ((t_nv & 255) == int'(m_reg[22])) m_vb <= 0;
            end
         end
         if (reg_we && !reg_sel) m_idx <= int'(reg_wdata[4:0]);
         if (reg_we && reg_sel && m_idx < 25 && !(m_idx <= 7 && m_reg[17][7]))
            m_reg[m_idx] <= reg_wdata;
      end
   end

   // per-cycle comparison, sampled 5 ns after each rising edge
   int exp_rd;
   always begin
      @(posedge clk);
      #5;
      if (!done) begin
         check(char_ce === (m_pix == CP - 1), "R4 char_ce", int'(char_ce), int'(m_pix == CP - 1));
         check(hsync === m_hs, "R9 hsync", int'(hsync), int'(m_hs));
         check(hblank === m_hb, "R8 hblank", int'(hblank), int'(m_hb));
         check(vsync === m_vs, "R10 vsync", int'(vsync), int'(m_vs));
         check(vblank === m_vb, "R11 vblank", int'(vblank), int'(m_vb));
         check(disp_en === (m_hc <= int'(m_reg[1]) && m_vc <= f_vde()),
               "R7 disp_en (R5/R6 counters)", int'(disp_en),
               int'(m_hc <= int'(m_reg[1]) && m_vc <= f_vde()));
         check(lcmp_hit === (m_vc == f_lc()), "R12 lcmp_hit", int'(lcmp_hit), int'(m_vc == f_lc()));
         exp_rd = !reg_sel ? m_idx : (m_idx < 25 ? int'(m_reg[m_idx]) : 0);
         check(reg_rdata === 8'(exp_rd), "R1 reg_rdata", int'(reg_rdata), exp_rd);
      end
   end

   // stimulus vectors: index, data, expected readback, requirement, clocks to run after
   localparam int NVEC = 31;
   localparam logic [47:0] VEC [NVEC] = '{
      {8'h00, 8'h33, 8'h33, 8'd1, 16'd0},
      {8'h11, 8'h85, 8'h85, 8'd3, 16'd0},
      {8'h00, 8'h77, 8'h33, 8'd3, 16'd0},
      {8'h07, 8'hFF, 8'h00, 8'd3, 16'd0},
      {8'h12, 8'h5A, 8'h5A, 8'd3, 16'd0},
      {8'h1F, 8'hAA, 8'h00, 8'd1, 16'd0},
      {8'h11, 8'h05, 8'h05, 8'd3, 16'd0},
      {8'h00, 8'h04, 8'h04, 8'd3, 16'd0},
      {8'h01, 8'h05, 8'h05, 8'd1, 16'd0},
      {8'h02, 8'h05, 8'h05, 8'd1, 16'd0},
      {8'h03, 8'h00, 8'h00, 8'd1, 16'd0},
      {8'h04, 8'h07, 8'h07, 8'd1, 16'd0},
      {8'h05, 8'h00, 8'h00, 8'd1, 16'd0},
      {8'h06, 8'h01, 8'h01, 8'd1, 16'd0},
      {8'h07, 8'h1F, 8'h1F, 8'd1, 16'd0},
      {8'h09, 8'h00, 8'h00, 8'd1, 16'd0},
      {8'h10, 8'h02, 8'h02, 8'd1, 16'd0},
      {8'h12, 8'h00, 8'h00, 8'd1, 16'd0},
      {8'h15, 8'h01, 8'h01, 8'd1, 16'd0},
      {8'h16, 8'h03, 8'h03, 8'd1, 16'd0},
      {8'h18, 8'h01, 8'h01, 8'd1, 16'd40000},
      {8'h00, 8'h24, 8'h24, 8'd1, 16'd0},
      {8'h03, 8'h01, 8'h01, 8'd1, 16'd0},
      {8'h05, 8'h80, 8'h80, 8'd1, 16'd0},
      {8'h06, 8'h10, 8'h10, 8'd1, 16'd0},
      {8'h07, 8'h00, 8'h00, 8'd1, 16'd0},
      {8'h10, 8'h08, 8'h08, 8'd1, 16'd0},
      {8'h12, 8'h09, 8'h09, 8'd1, 16'd0},
      {8'h15, 8'h0C, 8'h0C, 8'd1, 16'd0},
      {8'h16, 8'h02, 8'h02, 8'd1, 16'd0},
      {8'h18, 8'h04, 8'h04, 8'd1, 16'd15000}
   };

   task automatic port_write(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic port_read(input logic sel, output logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; reg_we = 1'b0;
      #2 d = reg_rdata;
   endtask

   task automatic run_clocks(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
   endtask

   // clocks between two rising edges of a strobe, sampled after each rising clock edge
   task automatic rise_period(input bit pick_v, output int period);
      bit prev, cur;
      int cnt;
      prev = 1'b1; cnt = -1; period = 0;
      for (int i = 0; i < 60000 && period == 0; i++) begin
         @(posedge clk); #5;
         cur = pick_v ? vsync : hsync;
         if (cnt >= 0) cnt++;
         if (cur && !prev) begin
            if (cnt < 0) cnt = 0;
            else period = cnt;
         end
         prev = cur;
      end
   endtask

   initial begin
      logic [7:0] rd;
      int per;
      int hs_rises;
      bit last_hs;
      // R2: reset state
      run_clocks(2); #5;
      check({char_ce, hsync, hblank, vsync, vblank} === 5'b0, "R2 reset outputs",
            int'({char_ce, hsync, hblank, vsync, vblank}), 0);
      check(reg_rdata === 8'h00, "R2 reset index", int'(reg_rdata), 0);
      @(negedge clk); rst_n = 1'b1;
      // R4: first char_ce on the seventh sample after release
      for (int k = 1; k <= 8; k++) begin
         @(posedge clk); #5;
         check(char_ce === (k == 7), "R4 first char_ce", int'(char_ce), int'(k == 7));
      end
      // table walk
      for (int i = 0; i < NVEC; i++) begin
         port_write(1'b0, VEC[i][47:40]);
         port_read(1'b0, rd);
         check(rd === (VEC[i][47:40] & 8'h1F), "R1 index readback", int'(rd), int'(VEC[i][47:40] & 8'h1F));
         port_write(1'b1, VEC[i][39:32]);
         port_read(1'b1, rd);
         if (rd !== VEC[i][31:24]) begin
            n_checks++; n_fail++;
            $display("FAIL R%0d: reg 0x%0h actual 0x%0h expected 0x%0h", VEC[i][23:16],
                     VEC[i][47:40], rd, VEC[i][31:24]);
         end else n_checks++;
         run_clocks(int'(VEC[i][15:0]));
         if (i == 20) begin
            rise_period(1'b0, per);
            check(per == 9 * CP, "R5 line length", per, 9 * CP);
            rise_period(1'b1, per);
            check(per == 259 * 9 * CP, "R6 frame length", per, 259 * 9 * CP);
         end
      end
      // R5 in the wide-line setting
      rise_period(1'b0, per);
      check(per == 41 * CP, "R5 wide line length", per, 41 * CP);
      // R9: hsync toggles at all
      hs_rises = 0; last_hs = hsync;
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk); #5;
         if (hsync && !last_hs) hs_rises++;
         last_hs = hsync;
      end
      check(hs_rises >= 5, "R9 hsync activity", hs_rises, 5);
      // R2: mid-run reset clears registers
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #5;
      check({hsync, hblank, vsync, vblank} === 4'b0, "R2 mid-run reset", int'({hsync, hblank, vsync, vblank}), 0);
      @(negedge clk); rst_n = 1'b1;
      port_read(1'b1, rd);
      check(rd === 8'h00, "R2 reg0 after reset", int'(rd), 0);
      run_clocks(100);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule